// File: doc/BRIEF.md
# Spread-Chip Parity Framer with BPSK Mapper

This block sits behind a spreading-code generator in a direct-sequence transmitter. It collects the coded chips that the generator delivers serially, 16 to a word, each one marked by a valid strobe. When a word is complete, the block computes the XOR of all 16 chips in one step and holds that bit in a single register. It then sends a 17-bit frame, one bit per clock. The 16 coded bits go out in the order they arrived, and the held even-parity bit goes last.

Each outgoing bit is also mapped to a bipolar BPSK symbol in two's complement, ready for a carrier modulator further down. A one-cycle marker flags the first bit of every frame, and an output-valid line covers exactly the 17 bits. The generator pauses for a couple of cycles between words. The framer uses that pause as its wait before transmitting, so a steady stream of words gives a steady stream of frames.

Top module: `parity_framer`

## Requirements
- R1: While reset is asserted and until the first frame begins, out_vld_o, frame_start_o, frame_bit_o are 0 and bpsk_sym_o is 2'b00.
- R2: The chip input is sampled only in cycles where chip_vld_i is 1. Chip values offered while chip_vld_i is 0 never appear in any frame and never start one.
- R3: The first frame bit appears on frame_bit_o GAP_CYCLES (default 2) clock cycles after the edge that accepts the 16th chip of a word. The coded bits leave in arrival order, first-received chip first.
- R4: A frame is 17 consecutive output cycles with out_vld_o held at 1: 16 coded bits, then one parity bit, with no hole inside the frame.
- R5: The 17th bit of each frame is the XOR of its 16 coded bits, so the XOR of all 17 frame bits is 0 (even parity).
- R6: frame_start_o is 1 for exactly one cycle per frame, on the frame's first bit, and only while out_vld_o is 1.
- R7: bpsk_sym_o is 2'b01 (+1) for a frame bit of 0, 2'b11 (-1) for a frame bit of 1, and 2'b00 whenever out_vld_o is 0.
- R8: Words that arrive back to back with the generator's 2-cycle pause between them each produce a complete, correct frame, with no bit lost or reordered.
- R9: Idle cycles inside a word (chip_vld_i low mid-word) do not reset the chip count. The word completes on its 16th valid chip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_i | input | 1 | Coded chip from the spreading generator |
| chip_vld_i | input | 1 | chip_i carries a chip this cycle |
| frame_bit_o | output | 1 | Serial frame bit (data or parity) |
| bpsk_sym_o | output | 2 | Two's-complement BPSK symbol: +1, -1 or 0 |
| frame_start_o | output | 1 | One-cycle marker on the first bit of a frame |
| out_vld_o | output | 1 | Output bit and symbol are valid |

## Verification
The bench builds the framer with its defaults: 16 chips per word and a 2-cycle wait. With these values the generator's 16-on, 2-off pattern lines up with the 17-bit output, so back-to-back words exercise the tightest case. In that case the parity bit of one frame is read out on the same edge that loads the next word and its parity. Word patterns of all zeros, all ones, odd and even weight, with and without mid-word pauses carrying inverted garbage, reach the order, latency and parity paths.

// File: rtl/parity_framer_pkg.sv
package parity_framer_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;
endpackage

// File: rtl/reset_sync.sv
module reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/chip_collector.sv
module chip_collector #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chip_i,
  input  logic         chip_vld_i,
  output logic         word_done_o,
  output logic [N-1:0] word_o,
  output logic         parity_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [N-1:0]  sr_q, sr_d;

  // next-state: write the chip at its slot, first chip in the top bit
  always_comb begin
    sr_d        = sr_q;
    cnt_d       = cnt_q;
    word_done_o = 1'b0;
    if (chip_vld_i) begin
      sr_d[CW'(N-1) - cnt_q] = chip_i;
      if (cnt_q == CW'(N-1)) begin
        cnt_d       = '0;
        word_done_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // parallel view of the completed word feeds the XOR reduction
  assign word_o   = sr_d;
  assign parity_o = ^sr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (chip_vld_i) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import parity_framer_pkg::*;
#(
  parameter int N   = 16,
  parameter int GAP = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] word_i,
  input  logic         parity_i,
  output logic         bit_o,
  output logic         vld_o,
  output logic         sof_o
);
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int IW = $clog2(N + 1);

  tx_state_e     st_q, st_d;
  logic [GW-1:0] wcnt_q, wcnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [N-1:0]  txsr_q, txsr_d;
  logic          par_q, par_d;
  logic          bit_q, bit_d, vld_q, vld_d, sof_q, sof_d;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    idx_d  = idx_q;
    txsr_d = txsr_q;
    par_d  = par_q;
    bit_d  = 1'b0;
    vld_d  = 1'b0;
    sof_d  = 1'b0;
    unique case (st_q)
      TX_WAIT: begin
        if (wcnt_q == GW'(GAP - 1)) begin
          bit_d  = txsr_q[N-1];
          vld_d  = 1'b1;
          sof_d  = 1'b1;
          txsr_d = txsr_q << 1;
          idx_d  = IW'(1);
          st_d   = TX_SEND;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      TX_SEND: begin
        vld_d = 1'b1;
        if (idx_q == IW'(N)) begin
          bit_d = par_q;          // mux selects the held parity bit
          st_d  = TX_IDLE;
        end else begin
          bit_d  = txsr_q[N-1];   // mux selects the next coded bit
          txsr_d = txsr_q << 1;
          idx_d  = idx_q + 1'b1;
        end
      end
      default: ;
    endcase
    if (load_i) begin
      st_d   = TX_WAIT;
      wcnt_d = '0;
      txsr_d = word_i;
      par_d  = parity_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      wcnt_q <= '0;
      idx_q  <= '0;
      txsr_q <= '0;
      par_q  <= 1'b0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
      sof_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      idx_q  <= idx_d;
      txsr_q <= txsr_d;
      par_q  <= par_d;
      bit_q  <= bit_d;
      vld_q  <= vld_d;
      sof_q  <= sof_d;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;
  assign sof_o = sof_q;
endmodule

// File: rtl/bpsk_mapper.sv
module bpsk_mapper
  import parity_framer_pkg::*;
(
  input  logic       bit_i,
  input  logic       vld_i,
  output logic [1:0] sym_o
);
  always_comb begin
    if (!vld_i)     sym_o = SYM_ZERO;
    else if (bit_i) sym_o = SYM_NEG;
    else            sym_o = SYM_POS;
  end
endmodule

// File: rtl/parity_framer.sv
module parity_framer #(
  parameter int CHIPS_PER_FRAME = 16,
  parameter int GAP_CYCLES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_i,
  input  logic       chip_vld_i,
  output logic       frame_bit_o,
  output logic [1:0] bpsk_sym_o,
  output logic       frame_start_o,
  output logic       out_vld_o
);
  logic                       rst_s_n;
  logic                       word_done;
  logic [CHIPS_PER_FRAME-1:0] word;
  logic                       word_par;

  reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  chip_collector #(.N(CHIPS_PER_FRAME)) u_coll (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .chip_i      (chip_i),
    .chip_vld_i  (chip_vld_i),
    .word_done_o (word_done),
    .word_o      (word),
    .parity_o    (word_par)
  );

  frame_serializer #(.N(CHIPS_PER_FRAME), .GAP(GAP_CYCLES)) u_ser (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load_i   (word_done),
    .word_i   (word),
    .parity_i (word_par),
    .bit_o    (frame_bit_o),
    .vld_o    (out_vld_o),
    .sof_o    (frame_start_o)
  );

  bpsk_mapper u_map (
    .bit_i (frame_bit_o),
    .vld_i (out_vld_o),
    .sym_o (bpsk_sym_o)
  );
endmodule

// File: rtl/parity_framer_chk.sv
module parity_framer_chk #(
  parameter int N = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_bit_o,
  input logic [1:0] bpsk_sym_o,
  input logic       frame_start_o,
  input logic       out_vld_o
);
  localparam int KW = $clog2(N + 2);

  logic [KW-1:0] seen_q;
  logic          acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      acc_q  <= 1'b0;
    end else if (out_vld_o) begin
      if (frame_start_o) begin
        seen_q <= KW'(1);
        acc_q  <= frame_bit_o;
      end else begin
        seen_q <= seen_q + 1'b1;
        acc_q  <= acc_q ^ frame_bit_o;
      end
    end
  end

  // R5
  parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && !frame_start_o && seen_q == KW'(N)) |-> ((acc_q ^ frame_bit_o) == 1'b0));

  // R4
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_vld_o) |-> ($past(seen_q) == KW'(N)));

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);

  // R6
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> out_vld_o);

  // R4
  rise_is_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld_o) |-> frame_start_o);

  // R7
  sym_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld_o |-> (bpsk_sym_o == 2'b00));

  // R7
  sym_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> (bpsk_sym_o == (frame_bit_o ? 2'b11 : 2'b01)));
endmodule

bind parity_framer parity_framer_chk #(.N(CHIPS_PER_FRAME)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_bit_o   (frame_bit_o),
  .bpsk_sym_o    (bpsk_sym_o),
  .frame_start_o (frame_start_o),
  .out_vld_o     (out_vld_o)
);

// File: tb/tb_parity_framer.sv
module tb_parity_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_i = 1'b0;
  logic       chip_vld_i = 1'b0;
  logic       frame_bit_o;
  logic [1:0] bpsk_sym_o;
  logic       frame_start_o;
  logic       out_vld_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [15:0] rx_word [0:31];
  logic        rx_par  [0:31];
  int          rx_sof  [0:31];
  int          nrx = 0;
  int          mcnt = 0;
  logic [15:0] mword = '0;
  int          msof = 0;
  int          last_take = 0;

  parity_framer dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .chip_i        (chip_i),
    .chip_vld_i    (chip_vld_i),
    .frame_bit_o   (frame_bit_o),
    .bpsk_sym_o    (bpsk_sym_o),
    .frame_start_o (frame_start_o),
    .out_vld_o     (out_vld_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // frame monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_vld_o) begin
        check(bpsk_sym_o == (frame_bit_o ? 2'b11 : 2'b01), "R7 symbol level",
              int'(bpsk_sym_o), frame_bit_o ? 3 : 1);
        if (frame_start_o) begin
          if (mcnt != 0) check(1'b0, "R6 start inside frame", mcnt, 0);
          mcnt = 1; mword = {15'd0, frame_bit_o}; msof = cyc;
        end else if (mcnt >= 1 && mcnt <= 15) begin
          mword = {mword[14:0], frame_bit_o}; mcnt++;
        end else if (mcnt == 16) begin
          rx_word[nrx] = mword; rx_par[nrx] = frame_bit_o; rx_sof[nrx] = msof;
          nrx++; mcnt = 0;
        end else begin
          check(1'b0, "R4 valid bit outside frame", 1, 0);
        end
      end else begin
        if (bpsk_sym_o != 2'b00) check(1'b0, "R7 idle symbol", int'(bpsk_sym_o), 0);
        if (mcnt != 0) begin
          check(1'b0, "R4 hole inside frame", mcnt, 17);
          mcnt = 0;
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); chip_vld_i = 1'b0; chip_i = i[0];
    end
  endtask

  task automatic send_word(input logic [15:0] w, input bit pause);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); chip_vld_i = 1'b1; chip_i = w[i];
      if (i == 0) last_take = cyc + 1;
      else if (pause && (i % 3 == 0)) begin
        @(negedge clk); chip_vld_i = 1'b0; chip_i = ~w[i];
        @(negedge clk); chip_vld_i = 1'b0; chip_i = ~w[i-1];
      end
    end
  endtask

  task automatic t_reset();
    check(out_vld_o == 1'b0, "R1 valid in reset", out_vld_o, 0);
    check(frame_start_o == 1'b0, "R1 start in reset", frame_start_o, 0);
    check(frame_bit_o == 1'b0, "R1 bit in reset", frame_bit_o, 0);
    check(bpsk_sym_o == 2'b00, "R1 symbol in reset", bpsk_sym_o, 0);
  endtask

  task automatic t_idle_noise();
    int n0 = nrx;
    idle(40);
    check(nrx == n0, "R2 frame from idle noise", nrx, n0);
    check(out_vld_o == 1'b0, "R2 valid after idle noise", out_vld_o, 0);
  endtask

  task automatic t_single(input logic [15:0] w, input bit pause, input string tag);
    int n0 = nrx;
    send_word(w, pause);
    idle(24);
    check(nrx == n0 + 1, {tag, " R4 frame count"}, nrx, n0 + 1);
    check(rx_word[n0] == w, {tag, " R3 R9 R2 bit order"}, rx_word[n0], w);
    check(rx_par[n0] == ^w, {tag, " R5 parity"}, rx_par[n0], ^w);
    check(rx_sof[n0] == last_take + 2, {tag, " R3 latency R6 start"}, rx_sof[n0], last_take + 2);
  endtask

  task automatic t_back_to_back();
    logic [15:0] ws [0:2];
    int tk [0:2];
    int n0 = nrx;
    ws[0] = 16'h1234; ws[1] = 16'hFFFE; ws[2] = 16'h0F0F;
    for (int k = 0; k < 3; k++) begin
      send_word(ws[k], 1'b0);
      tk[k] = last_take;
      idle(2);
    end
    idle(24);
    check(nrx == n0 + 3, "R8 frame count", nrx, n0 + 3);
    for (int k = 0; k < 3; k++) begin
      check(rx_word[n0+k] == ws[k], "R8 word", rx_word[n0+k], ws[k]);
      check(rx_par[n0+k] == ^ws[k], "R8 R5 parity", rx_par[n0+k], ^ws[k]);
      check(rx_sof[n0+k] == tk[k] + 2, "R8 R3 latency", rx_sof[n0+k], tk[k] + 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_idle_noise();
    t_single(16'h0000, 1'b0, "zeros");
    t_single(16'hFFFF, 1'b0, "ones");
    t_single(16'h8001, 1'b0, "ends");
    t_single(16'hA5A4, 1'b0, "odd");
    t_single(16'h6C3B, 1'b1, "paused");
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule